// File: doc/BRIEF.md
# Ring FIFO with Arbitrary Depth

This block is a single-clock, first-in first-out queue with one producer port and one consumer port. Its depth `DEPTH` can be any integer of two or more, including depths that are not powers of two. Each side keeps a slot index that counts from 0 up to `DEPTH-1` and then returns to 0. A separate lap bit toggles each time the index returns to 0. Comparing the two lap bits is how the block tells a full queue from an empty one, so every one of the `DEPTH` slots can hold data.

The producer raises `push` with `push_data`. The consumer raises `pop`, and the popped word appears on `pop_data` one cycle later. The outputs `is_full`, `is_empty` and `level` show the queue state in every cycle. Two sticky flags record any push made while the queue was full and any pop made while it was empty. Such requests are refused and change nothing else. The status logic classifies the pointer pair into one of three named states:
- `LVL_EMPTY`: the indices and the lap bits both match.
- `LVL_FULL`: the indices match and the lap bits differ.
- `LVL_PART`: every other case.

The state transitions follow from the accepted operations:
- An accepted push moves `LVL_EMPTY` to `LVL_PART`, or `LVL_PART` to `LVL_FULL` when one slot was left.
- An accepted pop moves `LVL_FULL` to `LVL_PART`, or `LVL_PART` to `LVL_EMPTY` when one word was left.
- An accepted push and pop in the same cycle keep the state.
- Reset forces `LVL_EMPTY`.

Top module: `ring_fifo_np2`

## Requirements
- R1: Each side's slot index counts 0 to DEPTH-1 and then returns to 0, toggling that side's lap bit. Words therefore leave in the order they entered, across any number of laps.
- R2: `is_empty` is 1 exactly when the two indices and the two lap bits are equal, which is when `level` is 0.
- R3: `is_full` is 1 exactly when the indices are equal and the lap bits differ. This happens after DEPTH more pushes than pops, so all DEPTH slots hold data.
- R4: `level` equals (write position − read position + 2·DEPTH) mod 2·DEPTH, where position = index + DEPTH·lap.
- R5: A push while `is_full` is 1 is refused. `level` and the stored data are unchanged.
- R6: A pop while `is_empty` is 1 is refused. `level` and `pop_data` are unchanged.
- R7: `ovf_seen` becomes 1 in the cycle after a refused push and stays 1 until reset.
- R8: `udf_seen` becomes 1 in the cycle after a refused pop and stays 1 until reset.
- R9: When the queue is neither empty nor full, a push and a pop in the same cycle are both accepted and `level` is unchanged.
- R10: An accepted pop presents the oldest stored word on `pop_data` after the next rising clock edge. `pop_data` holds its value until the next accepted pop.
- R11: Synchronous reset (`rst` = 1) clears both indices, both lap bits and both sticky flags. Afterwards `is_empty` = 1, `is_full` = 0 and `level` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| push | input | 1 | Write request |
| push_data | input | WIDTH | Word to store |
| pop | input | 1 | Read request |
| pop_data | output | WIDTH | Registered word from the last accepted pop |
| is_full | output | 1 | All DEPTH slots occupied |
| is_empty | output | 1 | No slot occupied |
| level | output | $clog2(DEPTH+1) | Number of stored words |
| ovf_seen | output | 1 | Sticky: a push was refused |
| udf_seen | output | 1 | Sticky: a pop was refused |

## Verification
The bench builds the block with DEPTH = 6 and WIDTH = 8. A depth of six is not a power of two, so the indices must skip from 5 back to 0 instead of rolling over naturally. This puts the gap between 5 and 8 in the pointer space within reach many times over a few thousand cycles. Random push and pop traffic drives the queue through many laps on both sides, and directed fills and drains reach the full and empty boundaries and the refused requests.

// File: rtl/ring_fifo_pkg.sv
package ring_fifo_pkg;
    typedef enum logic [1:0] {
        LVL_EMPTY = 2'd0,
        LVL_PART  = 2'd1,
        LVL_FULL  = 2'd2
    } fill_state_e;
endpackage

// File: rtl/ring_fifo_ptr.sv
module ring_fifo_ptr #(
    parameter int DEPTH = 6,
    localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             step,
    output logic [IDX_W-1:0] idx,
    output logic             lap
);
    localparam logic [IDX_W-1:0] LAST = IDX_W'(DEPTH - 1);

    always_ff @(posedge clk) begin
        if (rst) begin
            idx <= '0;
            lap <= 1'b0;
        end else if (step) begin
            if (idx == LAST) begin
                idx <= '0;
                lap <= ~lap;
            end else begin
                idx <= idx + 1'b1;
            end
        end
    end

    // R1: index never leaves the slot range
    assert_idx_bound_R1: assert property (@(posedge clk) disable iff (rst)
        (32'(idx) < DEPTH));

    // R1: stepping from the last slot returns to zero
    assert_idx_wrap_R1: assert property (@(posedge clk) disable iff (rst)
        (step && idx == LAST) |=> (idx == '0));
endmodule

// File: rtl/ring_fifo_mem.sv
module ring_fifo_mem #(
    parameter int DEPTH = 6,
    parameter int WIDTH = 8,
    localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             we,
    input  logic [IDX_W-1:0] waddr,
    input  logic [WIDTH-1:0] wdata,
    input  logic             re,
    input  logic [IDX_W-1:0] raddr,
    output logic [WIDTH-1:0] rdata
);
    logic [WIDTH-1:0] slots [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            slots[waddr] <= wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rdata <= '0;
        end else if (re) begin
            rdata <= slots[raddr];
        end
    end

    // R10: output register holds while no pop is accepted
    assert_rdata_hold_R10: assert property (@(posedge clk) disable iff (rst)
        !re |=> $stable(rdata));
endmodule

// File: rtl/ring_fifo_stat.sv
module ring_fifo_stat
    import ring_fifo_pkg::*;
#(
    parameter int DEPTH = 6,
    localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic [IDX_W-1:0] w_idx,
    input  logic             w_lap,
    input  logic [IDX_W-1:0] r_idx,
    input  logic             r_lap,
    output fill_state_e      state,
    output logic             full,
    output logic             empty,
    output logic [CNT_W-1:0] count
);
    localparam int EW = CNT_W + 1;
    logic [EW-1:0] diff;

    always_comb begin
        if (w_idx != r_idx)      state = LVL_PART;
        else if (w_lap == r_lap) state = LVL_EMPTY;
        else                     state = LVL_FULL;
    end

    always_comb begin
        unique case (state)
            LVL_EMPTY: begin full = 1'b0; empty = 1'b1; end
            LVL_FULL:  begin full = 1'b1; empty = 1'b0; end
            default:   begin full = 1'b0; empty = 1'b0; end
        endcase
    end

    always_comb begin
        if (w_lap == r_lap) diff = EW'(w_idx) - EW'(r_idx);
        else                diff = EW'(DEPTH) + EW'(w_idx) - EW'(r_idx);
        count = diff[CNT_W-1:0];
    end
endmodule

// File: rtl/ring_fifo_np2.sv
module ring_fifo_np2
    import ring_fifo_pkg::*;
#(
    parameter int DEPTH = 6,
    parameter int WIDTH = 8,
    localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             push,
    input  logic [WIDTH-1:0] push_data,
    input  logic             pop,
    output logic [WIDTH-1:0] pop_data,
    output logic             is_full,
    output logic             is_empty,
    output logic [CNT_W-1:0] level,
    output logic             ovf_seen,
    output logic             udf_seen
);
    logic [IDX_W-1:0] w_idx, r_idx;
    logic             w_lap, r_lap;
    logic             w_go, r_go;
    fill_state_e      state;

    assign w_go = push && !is_full;
    assign r_go = pop && !is_empty;

    ring_fifo_ptr #(.DEPTH(DEPTH)) wr_ptr_i (
        .clk(clk), .rst(rst), .step(w_go), .idx(w_idx), .lap(w_lap));

    ring_fifo_ptr #(.DEPTH(DEPTH)) rd_ptr_i (
        .clk(clk), .rst(rst), .step(r_go), .idx(r_idx), .lap(r_lap));

    ring_fifo_mem #(.DEPTH(DEPTH), .WIDTH(WIDTH)) mem_i (
        .clk(clk), .rst(rst), .we(w_go), .waddr(w_idx), .wdata(push_data),
        .re(r_go), .raddr(r_idx), .rdata(pop_data));

    ring_fifo_stat #(.DEPTH(DEPTH)) stat_i (
        .w_idx(w_idx), .w_lap(w_lap), .r_idx(r_idx), .r_lap(r_lap),
        .state(state), .full(is_full), .empty(is_empty), .count(level));

    always_ff @(posedge clk) begin
        if (rst) begin
            ovf_seen <= 1'b0;
            udf_seen <= 1'b0;
        end else begin
            if (push && is_full)  ovf_seen <= 1'b1;
            if (pop && is_empty)  udf_seen <= 1'b1;
        end
    end

    assert_empty_level_R2: assert property (@(posedge clk) disable iff (rst)
        is_empty == (level == '0));

    assert_full_level_R3: assert property (@(posedge clk) disable iff (rst)
        is_full == (32'(level) == DEPTH));

    assert_level_bound_R4: assert property (@(posedge clk) disable iff (rst)
        32'(level) <= DEPTH);

    assert_no_overflow_R5: assert property (@(posedge clk) disable iff (rst)
        (push && is_full && !pop) |=> (is_full && $stable(level)));

    assert_no_underflow_R6: assert property (@(posedge clk) disable iff (rst)
        (pop && is_empty && !push) |=> (is_empty && $stable(pop_data)));

    assert_ovf_sticky_R7: assert property (@(posedge clk) disable iff (rst)
        ovf_seen |=> ovf_seen);

    assert_udf_sticky_R8: assert property (@(posedge clk) disable iff (rst)
        udf_seen |=> udf_seen);

    assert_both_sides_R9: assert property (@(posedge clk) disable iff (rst)
        (push && pop && state == LVL_PART) |=> $stable(level));
endmodule

// File: tb/ring_fifo_np2_tb_top.sv
module ring_fifo_np2_tb_top;
    localparam int N = 6;
    localparam int W = 8;
    localparam int CW = $clog2(N + 1);

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          push = 1'b0, pop = 1'b0;
    logic [W-1:0]  push_data = '0;
    logic [W-1:0]  pop_data;
    logic          is_full, is_empty, ovf_seen, udf_seen;
    logic [CW-1:0] level;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    logic [W-1:0] q[$];
    logic [W-1:0] exp_rd = '0;
    bit m_ovf = 1'b0, m_udf = 1'b0;

    always #10 clk = ~clk;

    ring_fifo_np2 #(.DEPTH(N), .WIDTH(W)) dut_i (
        .clk(clk), .rst(rst), .push(push), .push_data(push_data), .pop(pop),
        .pop_data(pop_data), .is_full(is_full), .is_empty(is_empty),
        .level(level), .ovf_seen(ovf_seen), .udf_seen(udf_seen));

    function automatic bit m_full();  return q.size() == N; endfunction
    function automatic bit m_empty(); return q.size() == 0; endfunction

    task automatic chk(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic check_all();
        chk("R4 level", int'(level), q.size());
        chk("R2 empty", int'(is_empty), int'(m_empty()));
        chk("R3 full", int'(is_full), int'(m_full()));
        chk("R7 ovf", int'(ovf_seen), int'(m_ovf));
        chk("R8 udf", int'(udf_seen), int'(m_udf));
        chk("R10 data", int'(pop_data), int'(exp_rd));
    endtask

    // one clock cycle: drive at negedge, model at edge, check after edge
    task automatic step(bit w, logic [W-1:0] d, bit r);
        bit wok, rok, f, e;
        @(negedge clk);
        push = w; push_data = d; pop = r;
        f = m_full(); e = m_empty();
        wok = w && !f; rok = r && !e;
        @(posedge clk);
        if (w && f) m_ovf = 1'b1;
        if (r && e) m_udf = 1'b1;
        if (rok) exp_rd = q.pop_front();
        if (wok) q.push_back(d);
        #1;
        check_all();
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; push = 0; pop = 0;
        @(posedge clk); #1;
        @(negedge clk); rst = 1'b0;
        q.delete(); m_ovf = 0; m_udf = 0; exp_rd = '0;
        #1;
        check_all();
        chk("R11 empty after reset", int'(is_empty), 1);
    endtask

    initial begin
        void'($urandom(32'd4711));
        do_reset();
        // R3: all N slots usable
        for (int i = 0; i < N; i++) step(1'b1, W'(8'h10 + i), 1'b0);
        chk("R3 full after N pushes", int'(is_full), 1);
        // R5 / R7: refused push
        step(1'b1, 8'hEE, 1'b0);
        chk("R5 level held", int'(level), N);
        // R9 is not applicable when full; drain and verify order (R1)
        for (int i = 0; i < N; i++) step(1'b0, '0, 1'b1);
        chk("R1 last word in order", int'(pop_data), 8'h10 + N - 1);
        // R6 / R8: refused pop
        step(1'b0, '0, 1'b1);
        chk("R6 data held", int'(pop_data), 8'h10 + N - 1);
        // R9: simultaneous in partial state
        step(1'b1, 8'hA1, 1'b0);
        step(1'b1, 8'hA2, 1'b0);
        step(1'b1, 8'hA3, 1'b1);
        chk("R9 level kept", int'(level), 2);
        // R11: reset clears sticky flags
        do_reset();
        chk("R11 ovf cleared", int'(ovf_seen), 0);
        // random traffic across many laps (R1, R4)
        for (int i = 0; i < 4000; i++) begin
            int mode;
            mode = (i / 500) % 3;
            step(($urandom % 4) < (mode == 0 ? 3 : (mode == 1 ? 1 : 2)),
                 W'($urandom), ($urandom % 4) < (mode == 1 ? 3 : (mode == 0 ? 1 : 2)));
        end
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(20 * 100000);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule